// File: doc/BRIEF.md
# Machine Clock Mode Controller

This block decides which of three oscillator sources drives the machine clock: the main oscillator, a PLL-multiplied clock, or a low-speed sub-oscillator. Software writes one control word. That word holds a main/PLL select bit, a sub-clock select bit, a two-bit multiplier field with one extension bit, and a two-bit stabilization-wait field. The block then moves the running source toward the requested one. It does not switch at once. Going to the PLL from the main clock, or leaving the sub-clock, waits for an oscillator to settle, and an internal down-counter times that wait. Every other change waits for a one-cycle alignment strobe from the clock-domain logic. The strobe marks the instant when the two clocks involved line up.

The outputs are a one-hot source select for an external glitch-free clock mux and the multiplier code the PLL should run at. Two active-low indicator bits show the source that is really running. An error flag warns when a sub-clock-to-PLL move is set up with a wait that is too short. A clear sub-clock select bit always wins over the main/PLL select bit.

Top module: `mclk_mode_ctrl`

## Requirements
- R1: After reset the source is the main oscillator: src_main=1, src_pll=0, src_sub=0, both indicator bits read 1, both readable select bits read 1, pll_mult reads 000 and wait_err reads 0.
- R2: When both select bits are 0, the sub-clock is the goal. From the main clock no PLL wait starts, and the switch to the sub-clock happens on the main/sub strobe.
- R3: From the main clock, with main_sel=0 and sub_sel=1, the PLL becomes the source exactly L cycles after the write edge, where L is the wait length. It is the main clock before that.
- R4: The multiplier is {ext, m1, m0}. The only legal values are 000, 001, 010, 011 and 110. A write that carries an illegal value leaves the stored multiplier unchanged while it still updates the other fields. pll_mult shows the code latched when the PLL was entered.
- R5: In the PLL with main_sel=1 and sub_sel=1, the main clock returns only on the PLL/main strobe. The other two strobes have no effect.
- R6: From the main clock with sub_sel=0, the sub-clock takes over only on the main/sub strobe. The PLL/sub strobe has no effect.
- R7: From the PLL with sub_sel=0, the sub-clock takes over only on the PLL/sub strobe. The PLL/main strobe has no effect.
- R8: In the sub-clock with sub_sel=1, the source changes exactly L cycles after the write edge. It goes to the main clock when main_sel=1 and to the PLL when main_sel=0.
- R9: wait_err reads 1 from the cycle after a write that leaves the sub-clock bound for the PLL with a wait field of 00 or 01. It reads 0 once the PLL runs.
- R10: pll_run_n is 0 only while the PLL runs, and sub_run_n is 0 only while the sub-clock runs. Neither bit changes before the switch completes.
- R11: Wait field values 0, 1, 2 and 3 select 2^W0, 2^W1, 2^W2 and 2^W3 cycles.
- R12: A write replaces any pending target and restarts the wait. No source switch happens in the cycle of a write, even if a strobe or timer expiry falls in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_main_sel | input | 1 | 1 requests main clock, 0 requests PLL |
| wr_sub_sel | input | 1 | 0 requests sub-clock (overrides main_sel) |
| wr_mult | input | 2 | Multiplier field |
| wr_mult_ext | input | 1 | Multiplier extension bit |
| wr_wait | input | 2 | Stabilization-wait length select |
| algn_pll_main | input | 1 | PLL/main alignment strobe |
| algn_main_sub | input | 1 | Main/sub alignment strobe |
| algn_pll_sub | input | 1 | PLL/sub alignment strobe |
| src_main | output | 1 | Main oscillator selected |
| src_pll | output | 1 | PLL clock selected |
| src_sub | output | 1 | Sub-oscillator selected |
| pll_mult | output | 3 | Running multiplier code {ext, m1, m0} |
| pll_run_n | output | 1 | Low while the PLL is the running source |
| sub_run_n | output | 1 | Low while the sub-clock is the running source |
| main_sel | output | 1 | Stored main/PLL select bit |
| sub_sel | output | 1 | Stored sub-clock select bit |
| wait_err | output | 1 | Wait too short for a sub-to-PLL move |

## Verification
A control-word write can land in the same cycle as the event that would finish a pending switch. That event is either an alignment strobe or the wait counter reaching zero. The bench forces this case by raising the PLL/sub strobe in the write cycle itself, and by rewriting a long PLL wait as a short one partway through. The source must then stay put through the strobe. The short wait must run in full, counted from the second write edge, so the bench checks the exact cycle of the later switch.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  typedef enum logic [1:0] {SRC_MAIN = 2'd0, SRC_PLL = 2'd1, SRC_SUB = 2'd2} src_e;

  function automatic logic mult_legal(input logic [2:0] code);
    return !code[2] || (code[1:0] == 2'b10);
  endfunction
endpackage

// File: rtl/mcm_cfg_reg.sv
module mcm_cfg_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_main_sel,
  input  logic       wr_sub_sel,
  input  logic [1:0] wr_mult,
  input  logic       wr_mult_ext,
  input  logic [1:0] wr_wait,
  output logic       cfg_main_sel,
  output logic       cfg_sub_sel,
  output logic [2:0] cfg_mult,
  output logic [1:0] cfg_wait
);
  logic [2:0] new_mult;
  assign new_mult = {wr_mult_ext, wr_mult};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_main_sel <= 1'b1;
      cfg_sub_sel  <= 1'b1;
      cfg_mult     <= 3'b000;
      cfg_wait     <= 2'b00;
    end else if (wr_en) begin
      cfg_main_sel <= wr_main_sel;
      cfg_sub_sel  <= wr_sub_sel;
      cfg_wait     <= wr_wait;
      if (mcm_pkg::mult_legal(new_mult)) cfg_mult <= new_mult;
    end
  end

  // R4
  mult_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mcm_pkg::mult_legal(cfg_mult));
endmodule

// File: rtl/mcm_wait_timer.sv
module mcm_wait_timer #(
  parameter int W0 = 10,
  parameter int W1 = 13,
  parameter int W2 = 15,
  parameter int W3 = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] len_sel,
  output logic       expired
);
  localparam int M01  = (W0 > W1) ? W0 : W1;
  localparam int M23  = (W2 > W3) ? W2 : W3;
  localparam int WMAX = (M01 > M23) ? M01 : M23;
  localparam int CW   = WMAX + 1;

  logic [CW-1:0] cnt, load_val;
  int sh;

  always_comb begin
    case (len_sel)
      2'd0:    sh = W0;
      2'd1:    sh = W1;
      2'd2:    sh = W2;
      default: sh = W3;
    endcase
    load_val = (CW'(1) << sh) - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= load_val;
    else if (cnt != '0)         cnt <= cnt - CW'(1);
  end

  assign expired = run && !restart && (cnt == '0);

  // R11
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && run && !$past(restart) && $past(cnt) != '0) |-> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/mcm_mode_fsm.sv
module mcm_mode_fsm (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           cfg_main_sel,
  input  logic           cfg_sub_sel,
  input  logic [2:0]     cfg_mult,
  input  logic [1:0]     cfg_wait,
  input  logic           expired,
  input  logic           algn_pll_main,
  input  logic           algn_main_sub,
  input  logic           algn_pll_sub,
  output mcm_pkg::src_e  cur,
  output logic [2:0]     run_mult,
  output logic           wait_run,
  output logic           wait_err
);
  import mcm_pkg::*;
  src_e nxt;

  assign wait_run = (cur == SRC_MAIN && cfg_sub_sel && !cfg_main_sel) ||
                    (cur == SRC_SUB  && cfg_sub_sel);

  always_comb begin
    nxt = cur;
    if (!wr_en) begin
      case (cur)
        SRC_MAIN: begin
          if (!cfg_sub_sel) begin
            if (algn_main_sub) nxt = SRC_SUB;
          end else if (!cfg_main_sel && expired) nxt = SRC_PLL;
        end
        SRC_PLL: begin
          if (!cfg_sub_sel) begin
            if (algn_pll_sub) nxt = SRC_SUB;
          end else if (cfg_main_sel && algn_pll_main) nxt = SRC_MAIN;
        end
        default: begin
          if (cfg_sub_sel && expired) nxt = cfg_main_sel ? SRC_MAIN : SRC_PLL;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= SRC_MAIN;
      run_mult <= 3'b000;
      wait_err <= 1'b0;
    end else begin
      cur      <= nxt;
      if (nxt == SRC_PLL && cur != SRC_PLL) run_mult <= cfg_mult;
      wait_err <= (cur == SRC_SUB) && cfg_sub_sel && !cfg_main_sel && (cfg_wait < 2'd2);
    end
  end

  // R1
  reset_mode_chk: assert property (@(posedge clk) rst |=> (cur == SRC_MAIN && run_mult == 3'b000));
  // R6
  main_to_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == SRC_SUB && $past(cur) == SRC_MAIN) |-> $past(algn_main_sub));
  // R7
  pll_to_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == SRC_SUB && $past(cur) == SRC_PLL) |-> $past(algn_pll_sub));
  // R5
  pll_to_main_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == SRC_MAIN && $past(cur) == SRC_PLL) |-> $past(algn_pll_main));
  // R3
  pll_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == SRC_PLL && $past(cur) != SRC_PLL) |-> $past(expired));
  // R12
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (cur == $past(cur)));
endmodule

// File: rtl/mclk_mode_ctrl.sv
module mclk_mode_ctrl #(
  parameter int W0 = 10,
  parameter int W1 = 13,
  parameter int W2 = 15,
  parameter int W3 = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_main_sel,
  input  logic       wr_sub_sel,
  input  logic [1:0] wr_mult,
  input  logic       wr_mult_ext,
  input  logic [1:0] wr_wait,
  input  logic       algn_pll_main,
  input  logic       algn_main_sub,
  input  logic       algn_pll_sub,
  output logic       src_main,
  output logic       src_pll,
  output logic       src_sub,
  output logic [2:0] pll_mult,
  output logic       pll_run_n,
  output logic       sub_run_n,
  output logic       main_sel,
  output logic       sub_sel,
  output logic       wait_err
);
  import mcm_pkg::*;

  logic [2:0] cfg_mult;
  logic [1:0] cfg_wait;
  logic       expired, wait_run;
  src_e       cur;

  mcm_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_main_sel(wr_main_sel),
    .wr_sub_sel(wr_sub_sel), .wr_mult(wr_mult), .wr_mult_ext(wr_mult_ext),
    .wr_wait(wr_wait), .cfg_main_sel(main_sel), .cfg_sub_sel(sub_sel),
    .cfg_mult(cfg_mult), .cfg_wait(cfg_wait)
  );

  mcm_wait_timer #(.W0(W0), .W1(W1), .W2(W2), .W3(W3)) u_tmr (
    .clk(clk), .rst(rst), .run(wait_run), .restart(wr_en),
    .len_sel(wr_en ? wr_wait : cfg_wait), .expired(expired)
  );

  mcm_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cfg_main_sel(main_sel),
    .cfg_sub_sel(sub_sel), .cfg_mult(cfg_mult), .cfg_wait(cfg_wait),
    .expired(expired), .algn_pll_main(algn_pll_main),
    .algn_main_sub(algn_main_sub), .algn_pll_sub(algn_pll_sub),
    .cur(cur), .run_mult(pll_mult), .wait_run(wait_run), .wait_err(wait_err)
  );

  assign src_main  = (cur == SRC_MAIN);
  assign src_pll   = (cur == SRC_PLL);
  assign src_sub   = (cur == SRC_SUB);
  assign pll_run_n = !src_pll;
  assign sub_run_n = !src_sub;

  // R10
  onehot_src_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({src_main, src_pll, src_sub}));
  // R2
  sub_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!sub_sel && !main_sel && src_main) |=> !src_pll);
endmodule

// File: tb/test_mclk_mode_ctrl.sv
module test_mclk_mode_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, wr_main_sel = 1, wr_sub_sel = 1, wr_mult_ext = 0;
  logic [1:0] wr_mult = 0, wr_wait = 0;
  logic a_pm = 0, a_ms = 0, a_ps = 0;
  logic src_main, src_pll, src_sub, pll_run_n, sub_run_n, main_sel, sub_sel, wait_err;
  logic [2:0] pll_mult;
  int nchk = 0, nerr = 0;
  bit finished = 0;

  localparam logic [2:0] M = 3'b100, P = 3'b010, S = 3'b001;

  mclk_mode_ctrl #(.W0(2), .W1(3), .W2(4), .W3(5)) i_mclk_mode_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_main_sel(wr_main_sel),
    .wr_sub_sel(wr_sub_sel), .wr_mult(wr_mult), .wr_mult_ext(wr_mult_ext),
    .wr_wait(wr_wait), .algn_pll_main(a_pm), .algn_main_sub(a_ms),
    .algn_pll_sub(a_ps), .src_main(src_main), .src_pll(src_pll),
    .src_sub(src_sub), .pll_mult(pll_mult), .pll_run_n(pll_run_n),
    .sub_run_n(sub_run_n), .main_sel(main_sel), .sub_sel(sub_sel),
    .wait_err(wait_err)
  );

  always #10 clk = ~clk;

  function automatic int wlen(input logic [1:0] w);
    return 1 << (w + 2);
  endfunction

  task automatic chk_mode(input logic [2:0] exp, input string tag);
    logic [4:0] got, want;
    got  = {src_main, src_pll, src_sub, pll_run_n, sub_run_n};
    want = {exp, ~exp[1], ~exp[0]};
    nchk++;
    if (got !== want) begin
      nerr++;
      $display("FAIL %s mode got %b exp %b", tag, got, want);
    end
  endtask

  task automatic chk_val(input logic [2:0] got, input logic [2:0] exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic mn, input logic sb, input logic [1:0] m,
                    input logic x, input logic [1:0] w);
    @(negedge clk);
    wr_en = 1; wr_main_sel = mn; wr_sub_sel = sb; wr_mult = m; wr_mult_ext = x; wr_wait = w;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    a_pm = (which == 0); a_ms = (which == 1); a_ps = (which == 2);
    @(negedge clk);
    a_pm = 0; a_ms = 0; a_ps = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [2:0] exp_mult;
    int L;
    exp_mult = 3'b000;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk_mode(M, "R1 reset");
    chk_val({main_sel, sub_sel, wait_err}, 3'b110, "R1 select bits/err");
    chk_val(pll_mult, 3'b000, "R1 mult");

    // R3 R4 R5 R10 R11 sweep over all multiplier codes and wait fields
    for (int c = 0; c < 8; c++) begin
      logic [2:0] code;
      logic [1:0] w;
      code = 3'(c);
      w = 2'(c % 4);
      L = wlen(w);
      wr(0, 1, code[1:0], code[2], w);
      if (!code[2] || code[1:0] == 2'b10) exp_mult = code;
      repeat (L - 1) @(negedge clk);
      chk_mode(M, "R3 R10 R11 before wait end");
      @(negedge clk);
      chk_mode(P, "R3 R11 PLL after wait");
      chk_val(pll_mult, exp_mult, "R4 latched multiplier");
      wr(1, 1, code[1:0], code[2], w);
      repeat (3) @(negedge clk);
      chk_mode(P, "R5 R10 holds without strobe");
      pulse(1); pulse(2);
      chk_mode(P, "R5 wrong strobes ignored");
      pulse(0);
      chk_mode(M, "R5 back to main");
    end

    // R6 main to sub
    wr(1, 0, 0, 0, 0);
    pulse(2); pulse(0);
    chk_mode(M, "R6 wrong strobes ignored");
    pulse(1);
    chk_mode(S, "R6 sub on main/sub strobe");

    // R8 sub to main after wait
    wr(1, 1, 0, 0, 1);
    L = wlen(1);
    repeat (L - 1) @(negedge clk);
    chk_mode(S, "R8 before wait end");
    @(negedge clk);
    chk_mode(M, "R8 main after wait");

    // R2 both zero from main: no PLL wait
    wr(0, 0, 2'b01, 0, 0);
    repeat (40) @(negedge clk);
    chk_mode(M, "R2 no PLL entry");
    pulse(1);
    chk_mode(S, "R2 sub wins");

    // R9 short wait to PLL from sub, R8 to PLL
    wr(0, 1, 2'b11, 0, 1);
    L = wlen(1);
    @(negedge clk);
    chk_val({2'b00, wait_err}, 3'b001, "R9 error raised");
    repeat (L - 2) @(negedge clk);
    chk_mode(S, "R8 sub before wait end");
    @(negedge clk);
    chk_mode(P, "R8 PLL after wait");
    chk_val(pll_mult, 3'b011, "R8 multiplier");
    @(negedge clk);
    chk_val({2'b00, wait_err}, 3'b000, "R9 error cleared");

    // R7 PLL to sub, with R12 write in strobe cycle
    wr(0, 0, 2'b11, 0, 3);
    pulse(0);
    chk_mode(P, "R7 pll/main strobe ignored");
    @(negedge clk);
    wr_en = 1; a_ps = 1;
    @(negedge clk);
    wr_en = 0; a_ps = 0;
    chk_mode(P, "R12 write masks strobe");
    pulse(2);
    chk_mode(S, "R7 sub on pll/sub strobe");

    // R9 no error with long wait from sub to PLL
    wr(0, 1, 2'b10, 1, 2);
    @(negedge clk);
    chk_val({2'b00, wait_err}, 3'b000, "R9 no error long wait");
    repeat (wlen(2) - 1) @(negedge clk);
    chk_mode(P, "R8 PLL after long wait");
    chk_val(pll_mult, 3'b110, "R4 extended code");
    wr(1, 1, 0, 0, 0);
    pulse(0);
    chk_mode(M, "R5 main again");

    // R12 rewrite shortens pending wait
    wr(0, 1, 2'b01, 0, 3);
    repeat (10) @(negedge clk);
    wr(0, 1, 2'b01, 0, 0);
    repeat (wlen(0) - 1) @(negedge clk);
    chk_mode(M, "R12 restarted wait not done");
    @(negedge clk);
    chk_mode(P, "R12 switch after new wait");
    wr(1, 1, 0, 0, 0);
    pulse(0);
    chk_mode(M, "R5 main once more");

    // R12 target replaced: sub pending then PLL requested
    wr(1, 0, 0, 0, 0);
    wr(0, 1, 2'b00, 0, 1);
    pulse(1);
    chk_mode(M, "R12 stale strobe ignored");
    repeat (wlen(1)) @(negedge clk);
    chk_mode(P, "R12 new target reached");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule